// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block decides, once per clock, whether a 64-bit core enters an exception and of which kind. It watches four asynchronous requests (system reset, machine check, external interrupt, decrementer) and one synchronous request with a 10-bit cause code from the execute stage. It also samples the core's current program counter and machine state word. When a request wins arbitration, the registered outputs show, one cycle later, a one-cycle entry pulse and the entry kind. They also show the saved resume address, the saved status word, the replacement machine state value and the fetch redirect address.

Bit numbering in all 64-bit machine words is big-endian: bit 0 is the most significant bit, so big-endian bit b is vector index 63-b. The external-enable flag sits at big-endian bit 48 and the machine-check-enable flag at big-endian bit 51. Non-maskable sources are taken every cycle they are present, so one entry can overwrite the state saved by the entry before it. A synchronous request that arrives while the enable flag is clear does not enter. It latches a sticky error mode instead.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While rst_n is low and in the first cycle after it, take_o is 0, kind_o is 0, err_mode_o is 0, and srr0_o, srr1_o, new_msr_o and fetch_pc_o are all zero.
- R2: When several requests are present in one cycle, exactly one is taken, in this order: system reset, machine check, synchronous, external, decrementer. kind_o encodes the kind taken as 1 reset, 2 machine check, 3 synchronous, 4 external, 5 decrementer, and 0 when nothing is taken.
- R3: An entry decided at a clock edge shows take_o high for exactly one cycle after that edge. In that cycle srr0_o equals the cur_pc sampled at that edge.
- R4: In srr1_o, big-endian bits 0 to 32, 37 to 41 and 48 to 63 equal the same bits of the sampled cur_msr.
- R5: For a synchronous entry, sync_cause[9:6] lands in srr1_o big-endian bits 33 to 36 (cause[9] at bit 33), and sync_cause[5:0] lands in bits 42 to 47 (cause[5] at bit 42). For asynchronous entries those ten bits are zero.
- R6: new_msr_o is zero after a reset entry. After a machine-check entry it is cur_msr with big-endian bits 48 and 51 cleared. After any other entry it is cur_msr with bit 48 cleared.
- R7: fetch_pc_o is VEC_BASE plus 0x100 (reset), 0x200 (machine check), 0x700 (synchronous), 0x500 (external) or 0x900 (decrementer).
- R8: External and decrementer requests are ignored while cur_msr big-endian bit 48 is 0: no entry is taken and all saved outputs keep their values.
- R9: A machine check present on consecutive edges is taken at each edge. The second entry's resume address and status replace the first's.
- R10: A synchronous request that wins arbitration while bit 48 is 0 takes no entry and sets err_mode_o from the next cycle. err_mode_o stays set until a system reset entry or rst_n clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_rst_req | input | 1 | System reset request, non-maskable |
| mchk_req | input | 1 | Machine check request, non-maskable |
| sync_req | input | 1 | Synchronous exception request from execute |
| sync_cause | input | 10 | Cause code of the synchronous request |
| ext_req | input | 1 | External interrupt request, maskable |
| dec_req | input | 1 | Decrementer request, maskable |
| cur_pc | input | 64 | Address at which execution resumes |
| cur_msr | input | 64 | Current machine state word |
| take_o | output | 1 | Entry pulse, one cycle |
| kind_o | output | 3 | Kind of the entry taken |
| srr0_o | output | 64 | Saved resume address |
| srr1_o | output | 64 | Saved status word |
| new_msr_o | output | 64 | Machine state value to install |
| fetch_pc_o | output | 64 | Vector address to fetch from |
| err_mode_o | output | 1 | Sticky error mode flag |

## Verification
Every result is registered once, so the outputs for a request driven before edge k are due in the cycle after edge k. The bench drives inputs at a falling edge and samples at the next falling edge, which lands in exactly that cycle. It then withdraws the requests and leaves one idle edge before the next stimulus, except in the back-to-back machine-check test, where the request is held across two edges on purpose. Checks that something is ignored read the same cycle and compare every saved output with the value observed before.

// File: rtl/exc_pkg.sv
// Shared definitions for the exception entry controller.
// Assumes 64-bit words with big-endian bit numbering (bit 0 = MSB).
package exc_pkg;
    localparam int XLEN    = 64;
    localparam int CAUSE_W = 10;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_RESET = 3'd1,
        K_MCHK  = 3'd2,
        K_SYNC  = 3'd3,
        K_EXT   = 3'd4,
        K_DEC   = 3'd5
    } exc_kind_t;

    // Mask with ones over big-endian bits first..last.
    function automatic logic [XLEN-1:0] be_range(input int first, input int last);
        logic [XLEN-1:0] m;
        m = '0;
        for (int b = first; b <= last; b++) m[XLEN-1-b] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/exc_arbiter.sv
// Fixed-priority selection of the exception to take this cycle.
// Assumes requests are levels sampled once per clock; ext_en is the
// external-enable flag of the current machine state.
module exc_arbiter
    import exc_pkg::*;
(
    input  logic      rst_req,
    input  logic      mchk_req,
    input  logic      sync_req,
    input  logic      ext_req,
    input  logic      dec_req,
    input  logic      ext_en,
    output exc_kind_t kind,
    output logic      sync_fault
);
    // Pick the winner; a blocked synchronous request raises a fault instead.
    always_comb begin
        kind       = K_NONE;
        sync_fault = 1'b0;
        if (rst_req)                 kind = K_RESET;
        else if (mchk_req)           kind = K_MCHK;
        else if (sync_req) begin
            if (ext_en)              kind = K_SYNC;
            else                     sync_fault = 1'b1;
        end
        else if (ext_req && ext_en)  kind = K_EXT;
        else if (dec_req && ext_en)  kind = K_DEC;
    end
endmodule

// File: rtl/exc_status_pack.sv
// Builds the saved status word and the replacement machine state.
// Assumes the two cause fields together are CAUSE_W bits wide.
module exc_status_pack
    import exc_pkg::*;
#(
    parameter int EE_BE    = 48,
    parameter int ME_BE    = 51,
    parameter int CA_FIRST = 33,
    parameter int CA_LAST  = 36,
    parameter int CB_FIRST = 42,
    parameter int CB_LAST  = 47
) (
    input  exc_kind_t            kind,
    input  logic [CAUSE_W-1:0]   cause,
    input  logic [XLEN-1:0]      cur_msr,
    output logic [XLEN-1:0]      srr1,
    output logic [XLEN-1:0]      new_msr
);
    localparam int CA_W   = CA_LAST - CA_FIRST + 1;
    localparam int CB_W   = CB_LAST - CB_FIRST + 1;
    localparam int CA_MSB = XLEN - 1 - CA_FIRST;
    localparam int CB_MSB = XLEN - 1 - CB_FIRST;
    localparam int EE_IDX = XLEN - 1 - EE_BE;
    localparam int ME_IDX = XLEN - 1 - ME_BE;
    localparam logic [XLEN-1:0] COPY_MASK =
        ~(be_range(CA_FIRST, CA_LAST) | be_range(CB_FIRST, CB_LAST));

    logic [XLEN-1:0] cause_bits;

    // Place the cause code into its two fields for synchronous entries.
    always_comb begin
        cause_bits = '0;
        if (kind == K_SYNC) begin
            cause_bits[CA_MSB -: CA_W] = cause[CAUSE_W-1 -: CA_W];
            cause_bits[CB_MSB -: CB_W] = cause[CB_W-1:0];
        end
    end

    // Merge the copied state bits with the cause fields.
    always_comb srr1 = (cur_msr & COPY_MASK) | cause_bits;

    // Derive the machine state installed on entry.
    always_comb begin
        new_msr         = cur_msr;
        new_msr[EE_IDX] = 1'b0;
        case (kind)
            K_RESET: new_msr = '0;
            K_MCHK:  new_msr[ME_IDX] = 1'b0;
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_vector_gen.sv
// Maps an exception kind to its fetch address: base plus fixed offset.
// Assumes BASE leaves the low 12 bits free.
module exc_vector_gen
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] BASE     = 64'h0000_0000_FFF0_0000,
    parameter logic [11:0]     OFF_RST  = 12'h100,
    parameter logic [11:0]     OFF_MCHK = 12'h200,
    parameter logic [11:0]     OFF_SYNC = 12'h700,
    parameter logic [11:0]     OFF_EXT  = 12'h500,
    parameter logic [11:0]     OFF_DEC  = 12'h900
) (
    input  exc_kind_t       kind,
    output logic [XLEN-1:0] vec
);
    logic [11:0] off;

    // Select the per-kind offset.
    always_comb begin
        case (kind)
            K_RESET: off = OFF_RST;
            K_MCHK:  off = OFF_MCHK;
            K_SYNC:  off = OFF_SYNC;
            K_EXT:   off = OFF_EXT;
            K_DEC:   off = OFF_DEC;
            default: off = 12'h000;
        endcase
    end

    // Add the offset to the base.
    always_comb vec = BASE + {{(XLEN-12){1'b0}}, off};
endmodule

// File: rtl/exc_entry_ctrl.sv
// Exception entry controller: arbitrates requests, captures resume
// address and status, installs new machine state and redirects fetch.
// Assumes all outputs are used one cycle after the deciding edge.
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter logic [63:0] VEC_BASE = 64'h0000_0000_FFF0_0000,
    parameter int          EE_BE    = 48,
    parameter int          ME_BE    = 51
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sys_rst_req,
    input  logic        mchk_req,
    input  logic        sync_req,
    input  logic [9:0]  sync_cause,
    input  logic        ext_req,
    input  logic        dec_req,
    input  logic [63:0] cur_pc,
    input  logic [63:0] cur_msr,
    output logic        take_o,
    output logic [2:0]  kind_o,
    output logic [63:0] srr0_o,
    output logic [63:0] srr1_o,
    output logic [63:0] new_msr_o,
    output logic [63:0] fetch_pc_o,
    output logic        err_mode_o
);
    localparam int EE_IDX = XLEN - 1 - EE_BE;

    exc_kind_t       kind, kind_q;
    logic            sync_fault;
    logic [XLEN-1:0] srr1_d, new_msr_d, vec_d;

    exc_arbiter u_arb (
        .rst_req   (sys_rst_req),
        .mchk_req  (mchk_req),
        .sync_req  (sync_req),
        .ext_req   (ext_req),
        .dec_req   (dec_req),
        .ext_en    (cur_msr[EE_IDX]),
        .kind      (kind),
        .sync_fault(sync_fault)
    );

    exc_status_pack #(.EE_BE(EE_BE), .ME_BE(ME_BE)) u_pack (
        .kind   (kind),
        .cause  (sync_cause),
        .cur_msr(cur_msr),
        .srr1   (srr1_d),
        .new_msr(new_msr_d)
    );

    exc_vector_gen #(.BASE(VEC_BASE)) u_vec (
        .kind(kind),
        .vec (vec_d)
    );

    // Register the entry; saved state is only rewritten when an entry is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o     <= 1'b0;
            kind_q     <= K_NONE;
            srr0_o     <= '0;
            srr1_o     <= '0;
            new_msr_o  <= '0;
            fetch_pc_o <= '0;
        end else begin
            take_o <= (kind != K_NONE);
            kind_q <= kind;
            if (kind != K_NONE) begin
                srr0_o     <= cur_pc;
                srr1_o     <= srr1_d;
                new_msr_o  <= new_msr_d;
                fetch_pc_o <= vec_d;
            end
        end
    end

    // Sticky error mode: set by a blocked synchronous request, cleared by reset entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                err_mode_o <= 1'b0;
        else if (sync_fault)       err_mode_o <= 1'b1;
        else if (kind == K_RESET)  err_mode_o <= 1'b0;
    end

    assign kind_o = kind_q;
endmodule

// File: rtl/exc_entry_checker.sv
// Temporal checks on the exception entry controller, bound to its ports.
module exc_entry_checker #(
    parameter int EE_IDX = 15
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sys_rst_req,
    input logic        mchk_req,
    input logic        sync_req,
    input logic        ext_req,
    input logic        dec_req,
    input logic [63:0] cur_pc,
    input logic [63:0] cur_msr,
    input logic        take_o,
    input logic [2:0]  kind_o,
    input logic [63:0] srr0_o,
    input logic [63:0] new_msr_o,
    input logic        err_mode_o
);
    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> (take_o && kind_o == 3'd1)); // R2
    AST_RESUME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_req || mchk_req) |=> (srr0_o == $past(cur_pc))); // R3
    AST_EE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !new_msr_o[EE_IDX]); // R6
    AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_msr[EE_IDX] && !sys_rst_req && !mchk_req) |=> !take_o); // R8
    AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        mchk_req |=> take_o); // R9
    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && !cur_msr[EE_IDX] && !sys_rst_req && !mchk_req) |=> err_mode_o); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_mode_o && !sys_rst_req) |=> err_mode_o); // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(sys_rst_req || mchk_req || sync_req || ext_req || dec_req) |=> !take_o); // R2
endmodule

bind exc_entry_ctrl exc_entry_checker #(.EE_IDX(63 - EE_BE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_rst_req(sys_rst_req),
    .mchk_req   (mchk_req),
    .sync_req   (sync_req),
    .ext_req    (ext_req),
    .dec_req    (dec_req),
    .cur_pc     (cur_pc),
    .cur_msr    (cur_msr),
    .take_o     (take_o),
    .kind_o     (kind_o),
    .srr0_o     (srr0_o),
    .new_msr_o  (new_msr_o),
    .err_mode_o (err_mode_o)
);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
    localparam logic [63:0] BASE    = 64'h0000_0000_FFF0_0000;
    localparam logic [63:0] MSR_PAT = 64'hA5A5_5A5A_F0F0_0F0F;
    localparam int          EE_I    = 15;   // big-endian bit 48
    localparam int          ME_I    = 12;   // big-endian bit 51

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_rst_req = 0, mchk_req = 0, sync_req = 0, ext_req = 0, dec_req = 0;
    logic [9:0]  sync_cause = '0;
    logic [63:0] cur_pc = '0, cur_msr = '0;
    logic        take_o, err_mode_o;
    logic [2:0]  kind_o;
    logic [63:0] srr0_o, srr1_o, new_msr_o, fetch_pc_o;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [63:0] p_srr0, p_srr1, p_msr, p_fetch;

    always #5 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .sys_rst_req(sys_rst_req), .mchk_req(mchk_req),
        .sync_req(sync_req), .sync_cause(sync_cause), .ext_req(ext_req),
        .dec_req(dec_req), .cur_pc(cur_pc), .cur_msr(cur_msr), .take_o(take_o),
        .kind_o(kind_o), .srr0_o(srr0_o), .srr1_o(srr1_o), .new_msr_o(new_msr_o),
        .fetch_pc_o(fetch_pc_o), .err_mode_o(err_mode_o)
    );

    // {rst, mchk, sync, ext, dec}, ee, cause, expected kind, expected offset
    typedef struct packed {
        logic [4:0]  req;
        logic        ee;
        logic [9:0]  cause;
        logic [2:0]  kind;
        logic [11:0] off;
    } vec_t;
    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{5'b00010, 1'b1, 10'h000, 3'd4, 12'h500},
        '{5'b00001, 1'b1, 10'h000, 3'd5, 12'h900},
        '{5'b00011, 1'b1, 10'h000, 3'd4, 12'h500},
        '{5'b00100, 1'b1, 10'h2A5, 3'd3, 12'h700},
        '{5'b00110, 1'b1, 10'h35A, 3'd3, 12'h700},
        '{5'b01110, 1'b1, 10'h3FF, 3'd2, 12'h200},
        '{5'b11000, 1'b1, 10'h000, 3'd1, 12'h100},
        '{5'b00011, 1'b0, 10'h000, 3'd0, 12'h000},
        '{5'b01000, 1'b0, 10'h000, 3'd2, 12'h200},
        '{5'b00000, 1'b1, 10'h000, 3'd0, 12'h000}
    };

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_srr1(input logic [63:0] msr, input logic [9:0] c, input bit is_sync);
        logic [63:0] r;
        for (int b = 0; b < 64; b++) begin
            if (b >= 33 && b <= 36)      r[63-b] = is_sync ? c[9-(b-33)] : 1'b0;
            else if (b >= 42 && b <= 47) r[63-b] = is_sync ? c[5-(b-42)] : 1'b0;
            else                         r[63-b] = msr[63-b];
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_msr(input logic [63:0] msr, input logic [2:0] k);
        logic [63:0] r;
        r = msr;
        r[EE_I] = 1'b0;
        if (k == 3'd1) r = '0;
        if (k == 3'd2) r[ME_I] = 1'b0;
        return r;
    endfunction

    // Check outputs one cycle after the deciding edge (called at a falling edge).
    task automatic verify(input string tag, input logic [2:0] k, input logic [11:0] off,
                          input logic [63:0] pc, input logic [63:0] msr, input logic [9:0] c);
        chk(tag, "kind", {61'd0, kind_o}, {61'd0, k});
        chk(tag, "take", {63'd0, take_o}, {63'd0, (k != 3'd0)});
        if (k == 3'd0) begin
            chk(tag, "srr0 hold", srr0_o, p_srr0);
            chk(tag, "srr1 hold", srr1_o, p_srr1);
            chk(tag, "msr hold", new_msr_o, p_msr);
            chk(tag, "fetch hold", fetch_pc_o, p_fetch);
        end else begin
            chk(tag, "srr0 R3", srr0_o, pc);
            chk(tag, "srr1 R4 R5", srr1_o, exp_srr1(msr, c, k == 3'd3));
            chk(tag, "new msr R6", new_msr_o, exp_msr(msr, k));
            chk(tag, "fetch R7", fetch_pc_o, BASE + {52'd0, off});
        end
        p_srr0 = srr0_o; p_srr1 = srr1_o; p_msr = new_msr_o; p_fetch = fetch_pc_o;
    endtask

    task automatic drive(input logic [4:0] r, input logic ee, input logic [9:0] c, input logic [63:0] pc);
        {sys_rst_req, mchk_req, sync_req, ext_req, dec_req} = r;
        sync_cause = c;
        cur_pc = pc;
        cur_msr = MSR_PAT;
        cur_msr[EE_I] = ee;
    endtask

    task automatic clear_req();
        {sys_rst_req, mchk_req, sync_req, ext_req, dec_req} = 5'b0;
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] msr_v;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "take in reset", {63'd0, take_o}, 64'd0);
        chk("R1", "err in reset", {63'd0, err_mode_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "kind", {61'd0, kind_o}, 64'd0);
        chk("R1", "srr0", srr0_o, 64'd0);
        chk("R1", "srr1", srr1_o, 64'd0);
        chk("R1", "new msr", new_msr_o, 64'd0);
        chk("R1", "fetch", fetch_pc_o, 64'd0);
        p_srr0 = '0; p_srr1 = '0; p_msr = '0; p_fetch = '0;

        // R2 R3 R4 R5 R6 R7 R8: table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VT[i].req, VT[i].ee, VT[i].cause, 64'h0000_1000 + 64'(i * 4));
            msr_v = cur_msr;
            @(negedge clk);
            verify(VT[i].ee ? "R2" : "R8", VT[i].kind, VT[i].off,
                   64'h0000_1000 + 64'(i * 4), msr_v, VT[i].cause);
            clear_req();
        end

        // R9: machine check on two consecutive edges
        @(negedge clk);
        drive(5'b01000, 1'b1, 10'h0, 64'h0000_2000);
        msr_v = cur_msr;
        @(negedge clk);
        verify("R9", 3'd2, 12'h200, 64'h0000_2000, msr_v, 10'h0);
        cur_pc = 64'h0000_2040;
        cur_msr = MSR_PAT ^ 64'hFFFF_0000_0000_0000;
        cur_msr[EE_I] = 1'b0;
        msr_v = cur_msr;
        @(negedge clk);
        verify("R9", 3'd2, 12'h200, 64'h0000_2040, msr_v, 10'h0);
        clear_req();

        // R10: synchronous request with enable clear sets error mode, no entry
        @(negedge clk);
        drive(5'b00110, 1'b0, 10'h155, 64'h0000_3000);
        @(negedge clk);
        verify("R10", 3'd0, 12'h0, 64'h0, 64'h0, 10'h0);
        chk("R10", "err set", {63'd0, err_mode_o}, 64'd1);
        clear_req();
        // R10: stays set across a later normal entry
        @(negedge clk);
        drive(5'b00010, 1'b1, 10'h0, 64'h0000_3100);
        msr_v = cur_msr;
        @(negedge clk);
        verify("R10", 3'd4, 12'h500, 64'h0000_3100, msr_v, 10'h0);
        chk("R10", "err sticky", {63'd0, err_mode_o}, 64'd1);
        clear_req();
        // R10: reset entry clears it
        @(negedge clk);
        drive(5'b10000, 1'b0, 10'h0, 64'h0000_3200);
        msr_v = cur_msr;
        @(negedge clk);
        verify("R10", 3'd1, 12'h100, 64'h0000_3200, msr_v, 10'h0);
        chk("R10", "err cleared", {63'd0, err_mode_o}, 64'd0);
        clear_req();
        // R2 R10: blocked sync under a machine check takes the machine check, no error
        @(negedge clk);
        drive(5'b01100, 1'b0, 10'h0F0, 64'h0000_3300);
        msr_v = cur_msr;
        @(negedge clk);
        verify("R2", 3'd2, 12'h200, 64'h0000_3300, msr_v, 10'h0);
        chk("R10", "no err under mchk", {63'd0, err_mode_o}, 64'd0);
        clear_req();
        // R3: entry pulse lasts one cycle
        @(negedge clk);
        chk("R3", "pulse ends", {63'd0, take_o}, 64'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule